// File: doc/BRIEF.md
# Aligned Periodic Clock-Out Generator

This block drives a square wave onto a pin. The edges of the wave are fixed in absolute system time, not derived from a clock divider. A free-running 64-bit fixed-point system time value comes in from the timekeeping logic next to it. Software loads two values and then sets the enable bit:

- a start target, the absolute time of the first output edge;
- a half-period, the spacing between edges.

Both values are 64 bits in counter units and are written as two 32-bit halves. When system time reaches the target, the output level flips. The target then moves forward by exactly one half-period, so edges never drift, whatever the latency between cycles.

A pin configuration word decides whether the level actually leaves the block. The pin is driven only when its output-direction bit and its native-function bit are both set. Each level flip can raise a one-cycle interrupt pulse, gated by an interrupt-on-change control bit and by a mask bit. The mask bit is set through one address and cleared through another.

A sync control bit chooses how the time is compared. With it set, the comparison uses a registered copy of the time input, which relaxes the timing path at the cost of one cycle of edge latency. Software is expected to choose a start target on a whole-second boundary and a half-period of one second in counter units. Computing those values is outside this block.

Top module: `ocg_clkout_gen`

## Requirements
- R1: After synchronous reset, `pin_out`, `pin_oe` and `irq` are all 0, and every register holds 0.
- R2: A write with `wr_en` high updates one register at the next rising clock edge. The address map is:
  - 0: half-period bits 31:0
  - 1: half-period bits 63:32
  - 2: target bits 31:0
  - 3: target bits 63:32
  - 4: control, with bit0 = enable, bit1 = sync, bit2 = interrupt-on-change
  - 5: pin configuration, with bit0 = output direction, bit1 = native function
  - 6: mask set (a 1 in bit0 sets the mask bit)
  - 7: mask clear (a 1 in bit0 clears the mask bit)
- R3: With enable set and sync clear, the output level flips at the first rising edge where `sys_time` >= target. The new level is visible right after that edge.
- R4: Every flip advances the target by exactly the half-period, so successive flips are exactly one half-period of time apart.
- R5: If the target is already in the past when the unit is enabled, the first flip happens on the first edge after the enable write. Flips then repeat on each cycle until the target passes the time.
- R6: With sync set, the comparison uses the time registered one cycle earlier, so every flip happens one cycle later than it would with sync clear.
- R7: `irq` is a one-cycle pulse, coincident with each level flip, when the interrupt-on-change bit and the mask bit are both set. When either bit is clear, `irq` stays 0.
- R8: `pin_oe` is 1 only when both pin configuration bits are set. Otherwise `pin_out` is held at 0 while the internal level keeps running.
- R9: While enable is clear, no flip occurs. Writing 0 to the control word returns the level to 0 one cycle after the write takes effect.
- R10: The comparison spans all 64 bits. A target whose high half exceeds the time's high half never fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Current fixed-point system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Clock-out level, gated by the pin configuration |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | One-cycle interrupt pulse on each level flip |

## Verification
The following are checked on every cycle:
- Each compare hit flips the level.
- Each compare hit without a concurrent target write advances the stored target by exactly the half-period.
- An interrupt pulse only ever accompanies a level flip, and only with the interrupt-on-change and mask bits set in the previous cycle.
- A cleared enable forces the level low on the next cycle.

Only the bench scenarios can show when edges happen in absolute time:
- the exact time of the first edge for future and past targets;
- the one-cycle shift caused by the sync bit;
- the catch-up burst after a stale target;
- the full 64-bit comparison;
- pin gating, while the internal level keeps running.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

    localparam int DATA_W = 32;
    localparam int TIME_W = 2 * DATA_W;
    localparam int ADDR_W = 3;
    localparam int MASK_W = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_PER_LO  = 3'd0,
        A_PER_HI  = 3'd1,
        A_TGT_LO  = 3'd2,
        A_TGT_HI  = 3'd3,
        A_CTRL    = 3'd4,
        A_PINCFG  = 3'd5,
        A_MSK_SET = 3'd6,
        A_MSK_CLR = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic irq_on_chg;
        logic sync;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic native;
        logic dir;
    } pincfg_t;

    function automatic logic [TIME_W-1:0] put_half(
        input logic [TIME_W-1:0] old,
        input logic [DATA_W-1:0] d,
        input logic              hi
    );
        logic [TIME_W-1:0] r;
        r = old;
        if (hi) r[TIME_W-1:DATA_W] = d;
        else    r[DATA_W-1:0]      = d;
        return r;
    endfunction

endpackage

// File: rtl/ocg_regs.sv
module ocg_regs
    import ocg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TIME_W-1:0] period,
    output ctrl_t             ctrl,
    output pincfg_t           pincfg,
    output logic [MASK_W-1:0] mask,
    output logic              tgt_wr_lo,
    output logic              tgt_wr_hi
);

    reg_addr_e addr;

    always_comb begin
        addr      = reg_addr_e'(wr_addr);
        tgt_wr_lo = wr_en && (addr == A_TGT_LO);
        tgt_wr_hi = wr_en && (addr == A_TGT_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            ctrl   <= '0;
            pincfg <= '0;
            mask   <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PER_LO:  period <= put_half(period, wr_data, 1'b0);
                A_PER_HI:  period <= put_half(period, wr_data, 1'b1);
                A_CTRL:    ctrl   <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                A_PINCFG:  pincfg <= pincfg_t'(wr_data[$bits(pincfg_t)-1:0]);
                A_MSK_SET: mask   <= mask | wr_data[MASK_W-1:0];
                A_MSK_CLR: mask   <= mask & ~wr_data[MASK_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ocg_time_tap.sv
module ocg_time_tap
    import ocg_pkg::*;
#(
    parameter bit RETIME_EN = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_sel,
    input  logic [TIME_W-1:0] sys_time,
    output logic [TIME_W-1:0] cmp_time
);

    generate
        if (RETIME_EN) begin : g_retime
            logic [TIME_W-1:0] time_q;

            always_ff @(posedge clk) begin
                if (rst) time_q <= '0;
                else     time_q <= sys_time;
            end

            assign cmp_time = sync_sel ? time_q : sys_time;
        end else begin : g_direct
            logic unused_sel;

            assign unused_sel = sync_sel;
            assign cmp_time   = sys_time;
        end
    endgenerate

endmodule

// File: rtl/ocg_edge_sched.sv
module ocg_edge_sched
    import ocg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              irq_on_chg,
    input  logic [MASK_W-1:0] mask,
    input  logic [TIME_W-1:0] cmp_time,
    input  logic [TIME_W-1:0] period,
    input  logic              tgt_wr_lo,
    input  logic              tgt_wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TIME_W-1:0] target,
    output logic              fire,
    output logic              level,
    output logic              irq
);

    logic [TIME_W-1:0] next_target;

    always_comb begin
        fire        = en && (cmp_time >= target);
        next_target = target + period;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            level  <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= fire && irq_on_chg && mask[0];

            if (!en)       level <= 1'b0;
            else if (fire) level <= ~level;

            if (tgt_wr_lo)      target <= put_half(target, wr_data, 1'b0);
            else if (tgt_wr_hi) target <= put_half(target, wr_data, 1'b1);
            else if (fire)      target <= next_target;
        end
    end

endmodule

// File: rtl/ocg_clkout_gen.sv
module ocg_clkout_gen
    import ocg_pkg::*;
#(
    parameter bit RETIME_EN = 1'b1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] sys_time,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        pin_out,
    output logic        pin_oe,
    output logic        irq
);

    logic [TIME_W-1:0] period;
    logic [TIME_W-1:0] target;
    logic [TIME_W-1:0] cmp_time;
    ctrl_t             ctrl_q;
    pincfg_t           pincfg_q;
    logic [MASK_W-1:0] mask;
    logic              tgt_wr_lo;
    logic              tgt_wr_hi;
    logic              fire;
    logic              level;
    logic              ctl_en;
    logic              ctl_ie;
    logic              tgt_wr;

    ocg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period    (period),
        .ctrl      (ctrl_q),
        .pincfg    (pincfg_q),
        .mask      (mask),
        .tgt_wr_lo (tgt_wr_lo),
        .tgt_wr_hi (tgt_wr_hi)
    );

    ocg_time_tap #(.RETIME_EN(RETIME_EN)) u_tap (
        .clk      (clk),
        .rst      (rst),
        .sync_sel (ctrl_q.sync),
        .sys_time (sys_time),
        .cmp_time (cmp_time)
    );

    ocg_edge_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl_q.en),
        .irq_on_chg (ctrl_q.irq_on_chg),
        .mask       (mask),
        .cmp_time   (cmp_time),
        .period     (period),
        .tgt_wr_lo  (tgt_wr_lo),
        .tgt_wr_hi  (tgt_wr_hi),
        .wr_data    (wr_data),
        .target     (target),
        .fire       (fire),
        .level      (level),
        .irq        (irq)
    );

    assign ctl_en  = ctrl_q.en;
    assign ctl_ie  = ctrl_q.irq_on_chg;
    assign tgt_wr  = tgt_wr_lo | tgt_wr_hi;
    assign pin_oe  = pincfg_q.dir & pincfg_q.native;
    assign pin_out = level & pin_oe;

endmodule

// File: rtl/ocg_clkout_checker.sv
module ocg_clkout_checker (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        ie,
    input logic        mask,
    input logic        fire,
    input logic        tgt_wr,
    input logic [63:0] target,
    input logic [63:0] period,
    input logic        level,
    input logic        irq
);

    assert_toggle_on_fire_R3: assert property (@(posedge clk) disable iff (rst)
        fire |=> (level != $past(level)));

    assert_target_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !tgt_wr) |=> (target == $past(target) + $past(period)));

    assert_irq_with_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (level != $past(level)));

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ie && mask));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !level);

endmodule

bind ocg_clkout_gen ocg_clkout_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .en     (ctl_en),
    .ie     (ctl_ie),
    .mask   (mask[0]),
    .fire   (fire),
    .tgt_wr (tgt_wr),
    .target (target),
    .period (period),
    .level  (level),
    .irq    (irq)
);

// File: tb/ocg_clkout_gen_tb_top.sv
module ocg_clkout_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time = 64'd0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pin_out;
    logic        pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;
    bit prev_pin = 1'b0;

    typedef struct {
        longint unsigned t;
        bit              lvl;
        bit              irq;
    } exp_t;

    exp_t sb[$];

    ocg_clkout_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .sys_time(sys_time),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    always #5 clk = ~clk;

    // Time source: advances by one each cycle; value seen at a rising edge is stable around it.
    always @(negedge clk) sys_time <= sys_time + 64'd1;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a write that lands at the rising edge where sys_time == t (t==0: next edge).
    task automatic wr_at(input longint unsigned t, input logic [2:0] a,
                         input logic [31:0] d, output longint unsigned s);
        do begin
            @(negedge clk);
            #1;
        end while (t != 0 && sys_time < t);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        s       = sys_time;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        longint unsigned s;
        wr_at(0, a, d, s);
    endtask

    // Expected-edge generator from R3..R7, R9: enable lands at edge e, disable at edge d.
    task automatic predict(input longint unsigned e, input longint unsigned d,
                           input longint unsigned tgt, input longint unsigned per,
                           input bit sy, input bit ir);
        bit lvl;
        longint unsigned tg;
        lvl = 1'b0;
        tg  = tgt;
        for (longint unsigned t = e + 1; t <= d; t++) begin
            longint unsigned tq;
            tq = sy ? t - 1 : t;
            if (tq >= tg) begin
                lvl = ~lvl;
                sb.push_back('{t, lvl, ir});
                tg = tg + per;
            end
        end
        if (lvl) sb.push_back('{d + 1, 1'b0, 1'b0});
    endtask

    // Monitor: compares each observed pin transition with the scoreboard head.
    always begin
        @(posedge clk);
        #1;
        if (mon_on && !rst) begin
            if (pin_out != prev_pin) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3 unexpected edge", sys_time, 0);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk(sys_time == x.t, "R3/R4 edge time", sys_time, x.t);
                    chk(pin_out == x.lvl, "R3 edge level", pin_out, x.lvl);
                    chk(irq == x.irq, "R7 irq with edge", irq, x.irq);
                end
            end else if (irq) begin
                chk(1'b0, "R7 irq without edge", irq, 0);
            end
        end
        prev_pin = pin_out;
    end

    // Program the target, the half-period and the control word; run until the disable edge.
    task automatic run_case(input string tag, input longint signed tgt_off,
                            input longint unsigned per, input logic [31:0] tgt_hi_force,
                            input bit sy, input bit ir_exp, input int len);
        longint unsigned s;
        longint unsigned e;
        longint unsigned tgt;
        longint unsigned d;
        wr(3'd0, per[31:0]);
        wr(3'd1, per[63:32]);
        s   = sys_time;
        tgt = longint'(s) + tgt_off;
        if (tgt_hi_force != 0) tgt[63:32] = tgt_hi_force;
        wr(3'd2, tgt[31:0]);
        wr(3'd3, tgt[63:32]);
        wr_at(0, 3'd4, {29'd0, 1'b1, sy, 1'b1}, e);
        d = e + longint'(len);
        predict(e, d, tgt, per, sy, ir_exp);
        wr_at(d, 3'd4, 32'd0, s);
        repeat (4) @(posedge clk);
        #1;
        chk(sb.size() == 0, {tag, " all predicted edges seen"}, sb.size(), 0);
        chk(pin_out == 1'b0, "R9 level low after disable", pin_out, 0);
        sb.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(pin_out == 1'b0, "R1 pin_out reset", pin_out, 0);
        chk(pin_oe == 1'b0, "R1 pin_oe reset", pin_oe, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);

        // Pin enable needs both configuration bits (R8).
        wr(3'd5, 32'd1);
        #1 chk(pin_oe == 1'b0, "R8 dir only", pin_oe, 0);
        wr(3'd5, 32'd2);
        #1 chk(pin_oe == 1'b0, "R8 native only", pin_oe, 0);
        wr(3'd5, 32'd3);
        #1 chk(pin_oe == 1'b1, "R8 both bits", pin_oe, 1);
        mon_on = 1'b1;

        // R2 R3 R4 R7: future target, sync off, mask set.
        wr(3'd6, 32'd1);
        run_case("R3", 15, 5, 0, 1'b0, 1'b1, 40);

        // R5: stale target, sync off.
        run_case("R5", -3, 4, 0, 1'b0, 1'b1, 20);

        // R5 R6 R7: stale target, sync on, mask cleared -> no irq.
        wr(3'd7, 32'd1);
        run_case("R6", -12, 5, 0, 1'b1, 1'b0, 30);

        // R6: future target with sync on, mask set again.
        wr(3'd6, 32'd1);
        run_case("R6 future", 9, 7, 0, 1'b1, 1'b1, 35);

        // R10: high half of target beyond time -> never fires.
        run_case("R10", 2, 3, 32'd1, 1'b0, 1'b1, 30);

        // R8: level runs but pin is not driven.
        mon_on = 1'b0;
        wr(3'd5, 32'd2);
        begin
            int irq_seen;
            bit pin_hi;
            longint unsigned s;
            irq_seen = 0;
            pin_hi   = 1'b0;
            wr(3'd0, 32'd3);
            wr(3'd1, 32'd0);
            s = sys_time + 2;
            wr(3'd2, s[31:0]);
            wr(3'd3, s[63:32]);
            wr(3'd4, 32'd5);
            for (int i = 0; i < 20; i++) begin
                @(posedge clk);
                #1;
                if (irq) irq_seen++;
                if (pin_out || pin_oe) pin_hi = 1'b1;
            end
            chk(pin_hi == 1'b0, "R8 pin held off while running", pin_hi, 0);
            chk(irq_seen > 0, "R8 internal level still toggles", irq_seen, 1);
            wr(3'd4, 32'd0);
            repeat (2) @(posedge clk);
            wr(3'd5, 32'd3);
            #1 chk(pin_out == 1'b0 && pin_oe == 1'b1, "R9 level cleared when re-driven",
                   pin_out, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule